// File: doc/BRIEF.md
# I/O Port Wait-State Handshake Controller

This block stalls an 8-bit processor whenever it runs an I/O cycle to one configurable port. The stall lasts until a slow peripheral controller has finished with the transfer. It watches the low address byte and the active-low I/O request, read and write strobes. When the address equals the configured port number and a strobe is active, it latches a wait request that pulls the shared, wired-OR wait line low.

The wait latch is set only once per I/O cycle. It is cleared by a rising edge on the peripheral's release input, or by an optional down-counting timeout, so a peripheral that never answers cannot hang the processor. The system reset forces the latch to its released state, so the processor can never be blocked at power-on.

The line is modelled as an output enable plus a constant low data bit. An external pull-up supplies the high level. All bus pins are asynchronous to the block clock and pass through a synchronizer before any decision is made.

Top module: `iowait_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until the first stall, `wait_oe` is 0. `wait_o` is always 0, so the line is only ever pulled low or released.
- R2: `port_hit_n` is 0 when `bus_addr` equals `port_sel` and `bus_iorq_n` is 0, and 1 otherwise. It follows the pins 2 clocks after they change.
- R3: A qualified hit is the R2 match together with `bus_rd_n` = 0 or `bus_wr_n` = 0. A qualified hit sets `wait_oe` to 1 on the 3rd rising clock edge after the pins change.
- R4: No stall occurs in two cases: an I/O request to any other address, or an I/O request to the selected address with both strobes high.
- R5: Once set, `wait_oe` stays 1 until it is released by R6 or R8.
- R6: A 0-to-1 transition of `periph_done` clears `wait_oe` on the 3rd rising clock edge after it. Holding `periph_done` at 1 does not release a later stall.
- R7: After a release, no new stall occurs until `bus_iorq_n` has been seen high, even if the hit is still present.
- R8: When `tmo_limit` = L is not 0, a stall lasts exactly L clock cycles. `tmo_fired` is then 1 for exactly the first released cycle.
- R9: When `tmo_limit` is 0, the timeout is disabled and a stall lasts until R6.
- R10: The timeout count reloads on every new stall, so each stall gets the full L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| bus_addr | input | 8 | Low address byte of the processor bus |
| bus_iorq_n | input | 1 | Active-low I/O request |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| port_sel | input | 8 | Port number this block serves |
| tmo_limit | input | 8 | Timeout in clocks; 0 disables the timeout |
| periph_done | input | 1 | Release from the peripheral, acts on its rising edge |
| wait_oe | output | 1 | 1 pulls the wait line low; 0 releases it |
| wait_o | output | 1 | Data bit for the wait line, constant 0 |
| port_hit_n | output | 1 | Active-low port-match indication to the peripheral |
| tmo_fired | output | 1 | One-cycle pulse when the timeout releases the wait |

## Verification
Each result has a fixed latency from the pins that cause it:
- `port_hit_n` follows bus pins 2 clocks after they change.
- `wait_oe` rises 3 clocks after a qualified hit and falls 3 clocks after a release edge.
- A timed-out stall covers cycles 3 to L+2 after the hit, and `tmo_fired` is high in cycle L+3.

The driver tasks record the clock count at which they change an input and queue each expected value tagged with its due cycle. The monitor compares every queued item only in that cycle, sampling in the middle of the clock-high phase. An item that is missed or late counts as a mismatch.

// File: rtl/iowait_pkg.sv
package iowait_pkg;

  // Synchronized bus control strobes plus the peripheral release.
  typedef struct packed {
    logic iorq_n;
    logic rd_n;
    logic wr_n;
    logic done;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  // Idle bus: strobes inactive (high), release low.
  localparam ctl_t CTL_IDLE = '{iorq_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, done: 1'b0};

endpackage

// File: rtl/iowait_sync.sv
module iowait_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= RST_VAL;
        else        stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/iowait_decode.sv
module iowait_decode
  import iowait_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [ADDR_W-1:0] port_sel,
  input  ctl_t              ctl_s,
  output logic              port_hit_n,
  output logic              hit
);

  logic match_n;
  logic strobe;

  // Active-low comparison of the address byte against the configured port.
  assign match_n    = (addr_s != port_sel);
  assign strobe     = ~ctl_s.rd_n | ~ctl_s.wr_n;
  assign port_hit_n = match_n | ctl_s.iorq_n;
  assign hit        = ~port_hit_n & strobe;

endmodule

// File: rtl/iowait_timer.sv
module iowait_timer #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] limit,
  input  logic             clear,
  input  logic             run,
  output logic             expire
);

  logic [TMO_W-1:0] cnt;

  // A count of zero after load means the timeout is disabled for this stall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= limit;
    end else if (clear) begin
      cnt <= '0;
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - TMO_W'(1);
    end
  end

  assign expire = run && (cnt == TMO_W'(1));

endmodule

// File: rtl/iowait_latch.sv
module iowait_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic bus_idle,
  input  logic rel_rise,
  input  logic expire,
  output logic wait_q,
  output logic armed_q,
  output logic set_stall
);

  assign set_stall = hit & armed_q & ~wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
    end else if (set_stall) begin
      wait_q <= 1'b1;
    end else if (rel_rise || expire) begin
      wait_q <= 1'b0;
    end
  end

  // One stall per I/O cycle: re-arm only once the request is seen idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else if (set_stall) begin
      armed_q <= 1'b0;
    end else if (bus_idle) begin
      armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/iowait_ctrl.sv
module iowait_ctrl
  import iowait_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TMO_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_iorq_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [ADDR_W-1:0] port_sel,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              periph_done,
  output logic              wait_oe,
  output logic              wait_o,
  output logic              port_hit_n,
  output logic              tmo_fired
);

  ctl_t              ctl_raw;
  ctl_t              ctl_s;
  logic [ADDR_W-1:0] addr_s;
  logic              hit;
  logic              done_d;
  logic              rel_rise;
  logic              expire;
  logic              wait_q;
  logic              armed_q;
  logic              set_stall;
  logic              tmo_q;

  assign ctl_raw = '{iorq_n: bus_iorq_n, rd_n: bus_rd_n, wr_n: bus_wr_n, done: periph_done};

  iowait_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (bus_addr),
    .q    (addr_s)
  );

  iowait_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync_ctl (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ctl_raw),
    .q    (ctl_s)
  );

  iowait_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_s    (addr_s),
    .port_sel  (port_sel),
    .ctl_s     (ctl_s),
    .port_hit_n(port_hit_n),
    .hit       (hit)
  );

  // Rising-edge detect on the synchronized release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_d <= 1'b0;
    else        done_d <= ctl_s.done;
  end

  assign rel_rise = ctl_s.done & ~done_d;

  iowait_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .bus_idle (ctl_s.iorq_n),
    .rel_rise (rel_rise),
    .expire   (expire),
    .wait_q   (wait_q),
    .armed_q  (armed_q),
    .set_stall(set_stall)
  );

  iowait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (set_stall),
    .limit (tmo_limit),
    .clear (rel_rise),
    .run   (wait_q),
    .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= 1'b0;
    else        tmo_q <= expire;
  end

  // The line is open-drain: the enable pulls it low, the data bit never drives high.
  assign wait_oe   = wait_q;
  assign wait_o    = 1'b0;
  assign tmo_fired = tmo_q;

endmodule

// File: rtl/iowait_ctrl_chk.sv
module iowait_ctrl_chk #(
  parameter int unsigned TMO_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wait_oe,
  input logic             tmo_fired,
  input logic [TMO_W-1:0] tmo_limit,
  input logic             armed_q,
  input logic             set_stall,
  input logic             rel_rise,
  input logic             expire
);

  logic [TMO_W:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                held <= '0;
    else if (!wait_oe)         held <= '0;
    else if (!(&held))         held <= held + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_RELEASED: assert (!wait_oe); // R1
  end

  AST_STALL_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    set_stall |=> wait_oe); // R3

  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_oe && !rel_rise && !expire) |=> wait_oe); // R5

  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_oe && rel_rise) |=> !wait_oe); // R6

  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_oe && !armed_q) |=> !wait_oe); // R7

  AST_TMO_PULSE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fired |-> !wait_oe); // R8

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_oe && (tmo_limit != '0)) |-> (held < {1'b0, tmo_limit})); // R8

  AST_TMO_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_limit == '0) |=> !tmo_fired); // R9

endmodule

bind iowait_ctrl iowait_ctrl_chk #(.TMO_W(TMO_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wait_oe  (wait_oe),
  .tmo_fired(tmo_fired),
  .tmo_limit(tmo_limit),
  .armed_q  (armed_q),
  .set_stall(set_stall),
  .rel_rise (rel_rise),
  .expire   (expire)
);

// File: tb/iowait_ctrl_tb_top.sv
module iowait_ctrl_tb_top;

  localparam int F_WAIT = 0;
  localparam int F_HIT  = 1;
  localparam int F_TMO  = 2;
  localparam int F_LINE = 3;

  typedef struct {
    int    due;
    int    field;
    logic  exp;
    string req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_iorq_n = 1'b1;
  logic       bus_rd_n = 1'b1;
  logic       bus_wr_n = 1'b1;
  logic [7:0] port_sel = 8'hA5;
  logic [7:0] tmo_limit = 8'd0;
  logic       periph_done = 1'b0;
  logic       wait_oe, wait_o, port_hit_n, tmo_fired;

  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done_flag = 0;
  item_t q[$];

  always #10 clk = ~clk;

  iowait_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_iorq_n (bus_iorq_n),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .port_sel   (port_sel),
    .tmo_limit  (tmo_limit),
    .periph_done(periph_done),
    .wait_oe    (wait_oe),
    .wait_o     (wait_o),
    .port_hit_n (port_hit_n),
    .tmo_fired  (tmo_fired)
  );

  function automatic logic pick(int field);
    case (field)
      F_WAIT:  return wait_oe;
      F_HIT:   return port_hit_n;
      F_TMO:   return tmo_fired;
      default: return wait_o;
    endcase
  endfunction

  task automatic push(int due, int field, logic exp, string req);
    item_t it;
    it.due = due; it.field = field; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // Monitor: compares queued items in their due cycle, mid clock-high phase.
  always begin
    @(posedge clk);
    cyc++;
    #5;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic  act;
      it  = q.pop_front();
      act = pick(it.field);
      n_cmp++;
      if (it.due != cyc || act !== it.exp) begin
        n_bad++;
        $display("FAIL %s field=%0d cycle=%0d due=%0d actual=%b expected=%b",
                 it.req, it.field, cyc, it.due, act, it.exp);
      end
    end
  end

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic io_start(logic [7:0] a, logic rd, logic wr, logic exp_match,
                          logic exp_stall, string req, output int n);
    @(negedge clk);
    bus_addr = a; bus_iorq_n = 1'b0; bus_rd_n = ~rd; bus_wr_n = ~wr;
    n = cyc;
    push(n + 2, F_HIT, ~exp_match, req);
    push(n + 3, F_WAIT, exp_stall, req);
  endtask

  task automatic io_end(string req);
    int n;
    @(negedge clk);
    bus_iorq_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    n = cyc;
    push(n + 2, F_HIT, 1'b1, req);
  endtask

  task automatic pulse_done(string req);
    int n;
    @(negedge clk);
    periph_done = 1'b1;
    n = cyc;
    @(negedge clk);
    periph_done = 1'b0;
    push(n + 3, F_WAIT, 1'b0, req);
    push(n + 3, F_TMO, 1'b0, req);
  endtask

  task automatic direct(logic act, logic exp, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s direct actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    // R1: reset state
    idle(3);
    direct(wait_oe, 1'b0, "R1");
    direct(wait_o, 1'b0, "R1");
    direct(port_hit_n, 1'b1, "R2");
    direct(tmo_fired, 1'b0, "R8");
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    push(cyc + 1, F_WAIT, 1'b0, "R1");
    push(cyc + 1, F_LINE, 1'b0, "R1");

    // R2 R3: read hit on port 0xA5, held (R5), released by edge (R6)
    io_start(8'hA5, 1'b1, 1'b0, 1'b1, 1'b1, "R3", n);
    idle(12);
    push(cyc + 1, F_WAIT, 1'b1, "R5");
    push(cyc + 1, F_LINE, 1'b0, "R1");
    pulse_done("R6");
    idle(6);
    push(cyc + 1, F_WAIT, 1'b0, "R7");
    push(cyc + 1, F_HIT, 1'b0, "R2");
    io_end("R2");
    idle(4);

    // R4: other port, and selected port without strobe
    io_start(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, "R4", n);
    idle(6);
    push(cyc + 1, F_WAIT, 1'b0, "R4");
    io_end("R4");
    idle(4);
    io_start(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, "R4", n);
    idle(6);
    push(cyc + 1, F_WAIT, 1'b0, "R4");
    io_end("R4");
    idle(4);

    // New port 0x3C, write hit; level-held release does not free a later stall
    @(negedge clk);
    port_sel = 8'h3C;
    idle(3);
    io_start(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, "R3", n);
    idle(4);
    @(negedge clk);
    periph_done = 1'b1;
    push(cyc + 3, F_WAIT, 1'b0, "R6");
    idle(5);
    io_end("R7");
    idle(4);
    io_start(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, "R6", n);
    idle(8);
    push(cyc + 1, F_WAIT, 1'b1, "R6");
    @(negedge clk);
    periph_done = 1'b0;
    idle(2);
    pulse_done("R6");
    io_end("R6");
    idle(4);

    // R8: timeout after 5 cycles, then R10 reload on a second stall
    @(negedge clk);
    tmo_limit = 8'd5;
    for (int s = 0; s < 2; s++) begin
      io_start(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, "R8", n);
      for (int k = 3; k <= 7; k++) push(n + k, F_WAIT, 1'b1, (s == 0) ? "R8" : "R10");
      push(n + 8, F_WAIT, 1'b0, "R8");
      push(n + 8, F_TMO, 1'b1, "R8");
      push(n + 9, F_TMO, 1'b0, "R8");
      push(n + 14, F_WAIT, 1'b0, "R7");
      idle(15);
      io_end("R8");
      idle(4);
    end

    // R9: zero timeout never auto-releases
    @(negedge clk);
    tmo_limit = 8'd0;
    io_start(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, "R9", n);
    idle(300);
    push(cyc + 1, F_WAIT, 1'b1, "R9");
    push(cyc + 1, F_TMO, 1'b0, "R9");
    pulse_done("R9");
    io_end("R9");
    idle(4);

    // R1: reset during a stall releases the line at once
    io_start(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, "R3", n);
    idle(6);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    direct(wait_oe, 1'b0, "R1");
    bus_iorq_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    idle(2);
    rst_n = 1'b1;
    idle(5);
    push(cyc + 1, F_WAIT, 1'b0, "R1");
    idle(4);

    while (q.size() > 0) @(negedge clk);
    done_flag = 1;
    summary();
    $finish;
  end

endmodule